// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block is the command front end of a serial memory that sits on an SPI bus as a slave (mode 0: data sampled on the rising clock edge, changed on the falling edge). It watches the chip select, serial clock and serial data input. It decodes four one-byte commands: status read, latch set, latch clear and status write. It keeps the status bits the memory exposes to the host: a write-enable latch, two block-protect bits, a protect-enable bit and a busy flag. The status byte is shifted back on the serial output.

The serial pins are sampled by the block's own system clock through a synchronizer, so the serial clock must be several times slower than the system clock. The nonvolatile program cycle is modelled by a down counter of programmable length. The protect bits are plain flops that take their new value only when that counter expires. A host sets the latch, issues the status write, then polls the busy flag, either with repeated reads or by clocking one read for as long as it likes.

Top module: `serstat_front`

## Requirements
- R1: After reset the status byte reads 8'h00 and the serial output is not driven (`soDrive` = 0).
- R2: Opcode 8'h05, sent MSB first, returns the status byte MSB first, starting on the falling edge after the 8th opcode bit. The byte is bit7 = protect enable, bits 6..4 = 0, bit3 = upper block-protect, bit2 = lower block-protect, bit1 = write-enable latch, bit0 = busy.
- R3: `soDrive` is 0 during the eight opcode bits and while chip select is high. It is 1 during the data phase of a status read.
- R4: Opcode 8'h06 sets the write-enable latch and opcode 8'h04 clears it. Each acts when chip select rises after exactly 8 serial clocks.
- R5: A command ended by chip select after a count of clocks other than its own (8 for 8'h06/8'h04, 16 for 8'h01) has no effect, and the next command is decoded from its first bit.
- R6: Opcode 8'h01 followed by a data byte D, with the latch set, sets busy for exactly BUSY_CYCLES system clocks. At the end of that time, protect enable = D[7], upper protect = D[3] and lower protect = D[2], and the latch clears. D[6:4] and D[1:0] are dropped.
- R7: Opcode 8'h01 with the latch clear changes nothing and does not set busy.
- R8: While busy is set, the status read still works and shows busy = 1. Opcodes 8'h01, 8'h06 and 8'h04 are ignored while busy.
- R9: If a status read keeps clocking with chip select low, every further group of 8 clocks carries the current status byte, so the busy bit can be seen to fall within one read.
- R10: Any other opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the block |
| soData | output | 1 | Serial data out of the block |
| soDrive | output | 1 | High when `soData` is to be driven; low means high impedance |

## Verification
A status read can be shifting out its byte in the very cycle the busy counter expires and commits the protect bits and clears the latch. Also, a latch or status-write command can finish while busy is still set. The bench starts a status write and then clocks one long read across the end of the busy time. It expects busy set with the old bits in the first byte and the new bits with the latch clear in the last byte. It also issues latch-clear and status-write commands during the busy time and expects them to leave no trace once the cycle ends.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  localparam logic [7:0] OP_READ_STAT  = 8'h05;
  localparam logic [7:0] OP_LATCH_SET  = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR  = 8'h04;
  localparam logic [7:0] OP_WRITE_STAT = 8'h01;

  // one-cycle requests from the command decoder to the status datapath
  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       wrReq;
    logic [2:0] wrBits;   // {protect enable, upper protect, lower protect}
  } ctrlStrobe_t;
endpackage

// File: rtl/serstat_ctrl.sv
module serstat_ctrl
  import serstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        si,
  input  logic [7:0]  statusByte,
  output ctrlStrobe_t strobe,
  output logic        soData,
  output logic        soDrive
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]  csPipe, sckPipe;
  logic [SYNC_STAGES-1:0] siPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      siPipe  <= '0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-1:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-1:0], sck};
      siPipe  <= {siPipe[SYNC_STAGES-2:0], si};
    end
  end

  logic csHigh, csRise, sckRise, sckFall, siBit;
  assign csHigh  = csPipe[LAST];
  assign csRise  = csPipe[LAST] & ~csPipe[SYNC_STAGES];
  assign sckRise = sckPipe[LAST] & ~sckPipe[SYNC_STAGES];
  assign sckFall = ~sckPipe[LAST] & sckPipe[SYNC_STAGES];
  assign siBit   = siPipe[LAST];

  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic [7:0] opReg, datReg, shReg;
  logic       readMode;
  logic [7:0] opNext;

  assign opNext = {opReg[6:0], siBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      opReg    <= '0;
      datReg   <= '0;
      shReg    <= '0;
      readMode <= 1'b0;
    end else if (csHigh) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      readMode <= 1'b0;
    end else begin
      if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7 && byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
        if (byteCnt == 2'd0) opReg <= opNext;
        if (byteCnt == 2'd1) datReg <= {datReg[6:0], siBit};
        if (byteCnt == 2'd0 && bitCnt == 3'd7 && opNext == OP_READ_STAT)
          readMode <= 1'b1;
      end
      if (sckFall && readMode)
        shReg <= (bitCnt == 3'd0) ? statusByte : {shReg[6:0], 1'b0};
    end
  end

  logic exactOne, exactTwo;
  assign exactOne = (byteCnt == 2'd1) && (bitCnt == 3'd0);
  assign exactTwo = (byteCnt == 2'd2) && (bitCnt == 3'd0);

  always_comb begin
    strobe.setWel = csRise && exactOne && (opReg == OP_LATCH_SET);
    strobe.clrWel = csRise && exactOne && (opReg == OP_LATCH_CLR);
    strobe.wrReq  = csRise && exactTwo && (opReg == OP_WRITE_STAT);
    strobe.wrBits = {datReg[7], datReg[3], datReg[2]};
  end

  assign soData  = shReg[7];
  assign soDrive = readMode & ~csHigh;
endmodule

// File: rtl/serstat_dp.sv
module serstat_dp
  import serstat_pkg::*;
#(
  parameter int BUSY_CYCLES = 1500
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic [7:0]  statusByte
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic          wel, wip;
  logic [2:0]    protBits, pendBits;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel      <= 1'b0;
      wip      <= 1'b0;
      protBits <= '0;
      pendBits <= '0;
      busyCnt  <= '0;
    end else if (wip) begin
      busyCnt <= busyCnt - CW'(1);
      if (busyCnt == CW'(1)) begin
        wip      <= 1'b0;
        wel      <= 1'b0;
        protBits <= pendBits;
      end
    end else if (strobe.wrReq && wel) begin
      wip      <= 1'b1;
      busyCnt  <= CW'(BUSY_CYCLES);
      pendBits <= strobe.wrBits;
    end else if (strobe.setWel) begin
      wel <= 1'b1;
    end else if (strobe.clrWel) begin
      wel <= 1'b0;
    end
  end

  assign statusByte = {protBits[2], 3'b000, protBits[1:0], wel, wip};
endmodule

// File: rtl/serstat_front.sv
module serstat_front
  import serstat_pkg::*;
#(
  parameter int BUSY_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic soData,
  output logic soDrive
);
  ctrlStrobe_t strobe;
  logic [7:0]  statusByte;

  serstat_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .statusByte(statusByte), .strobe(strobe),
    .soData(soData), .soDrive(soDrive)
  );

  serstat_dp #(.BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusByte(statusByte)
  );
endmodule

// File: rtl/serstat_chk.sv
module serstat_chk #(
  parameter int BUSY_CYCLES = 1500
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       soDrive,
  input logic [7:0] statusByte
);
  logic wip, wel;
  assign wip = statusByte[0];
  assign wel = statusByte[1];

  logic [31:0] wipLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    wipLen <= '0;
    else if (wip) wipLen <= wipLen + 32'd1;
    else          wipLen <= '0;
  end

  p_hiz_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !soDrive);

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> (wipLen == BUSY_CYCLES));

  p_busy_needs_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> wel);

  p_latch_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  p_latch_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !$past(wip));

  p_prot_commit_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(wip) |-> $stable(statusByte[7:2]));
endmodule

bind serstat_front serstat_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .soDrive(soDrive), .statusByte(statusByte)
);

// File: tb/tb_serstat_front.sv
`timescale 1ns/1ps
module tb_serstat_front;
  localparam int BUSY = 1500;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic soData, soDrive;
  int nChk = 0, nBad = 0;
  logic       mWel = 1'b0;
  logic [2:0] mProt = 3'b000;

  always #4 clk = ~clk;

  serstat_front #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soDrive(soDrive)
  );

  function automatic logic [7:0] expStat(input logic busy);
    return {mProt[2], 3'b000, mProt[1:0], mWel, busy};
  endfunction

  task automatic clkWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] dat, input int nbits,
                      output logic [7:0] first, output logic [7:0] last, output int hizBad);
    logic [7:0] sh = '0;
    hizBad = 0; first = '0; last = '0;
    csN = 1'b0; clkWait(8);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 8) ? op[7-i] : ((i < 16) ? dat[15-i] : 1'b0);
      clkWait(8);
      if (i < 8) begin
        if (soDrive) hizBad++;
      end else begin
        sh = {sh[6:0], soData};
        if (!soDrive) hizBad++;
        if (((i - 8) % 8) == 7) begin
          if (i == 15) first = sh;
          last = sh;
        end
      end
      sck = 1'b1; clkWait(8); sck = 1'b0;
    end
    clkWait(8); csN = 1'b1; clkWait(8);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] dat, input int nbits);
    logic [7:0] f, l; int h;
    xfer(op, dat, nbits, f, l, h);
  endtask

  task automatic readStat(output logic [7:0] s);
    logic [7:0] l; int h;
    xfer(8'h05, 8'h00, 16, s, l, h);
    chk("R3 no drive in opcode phase, drive in data", 8'(h), 8'h00);
    chk("R3 released after chip select", {7'b0, soDrive}, 8'h00);
  endtask

  task automatic checkStat(input string req);
    logic [7:0] s;
    readStat(s);
    chk(req, s, expStat(1'b0));
  endtask

  // accepted status write: poll while busy, then commit in the model
  task automatic waitCommit(input logic [7:0] d);
    logic [7:0] s;
    int polls = 0;
    do begin
      readStat(s);
      polls++;
      if (s[0]) chk("R8 busy read shows old bits", s, expStat(1'b1));
    end while (s[0] && polls < 20);
    mProt = {d[7], d[3], d[2]};
    mWel  = 1'b0;
    chk("R6 committed bits, latch cleared", s, expStat(1'b0));
  endtask

  initial begin
    logic [7:0] s, f, l;
    int h;
    void'($urandom(32'd20240611));
    clkWait(5); rstN = 1'b1; clkWait(4);
    chk("R1 output idle after reset", {7'b0, soDrive}, 8'h00);
    checkStat("R1 reset status");

    cmd(8'h06, 8'h00, 8);  mWel = 1'b1; checkStat("R4 latch set");
    cmd(8'h04, 8'h00, 8);  mWel = 1'b0; checkStat("R4 latch clear");
    cmd(8'h01, 8'hFF, 16); checkStat("R7 status write refused with latch clear");
    cmd(8'h06, 8'h00, 8);  mWel = 1'b1;
    cmd(8'h04, 8'h00, 5);  checkStat("R5 truncated clear ignored");
    cmd(8'h04, 8'h00, 9);  checkStat("R5 overlong clear ignored");
    cmd(8'h01, 8'h8C, 12); checkStat("R5 truncated status write ignored");
    cmd(8'h02, 8'h00, 8);  checkStat("R10 unknown opcode ignored");

    // busy window: commands ignored, status still readable
    cmd(8'h01, 8'h8C, 16);
    readStat(s); chk("R8 busy readable", s, 8'h03);
    cmd(8'h04, 8'h00, 8);
    cmd(8'h01, 8'h00, 16);
    readStat(s); chk("R8 clear and write ignored while busy", s, 8'h03);
    waitCommit(8'h8C);
    chk("R2 layout of committed byte", expStat(1'b0), 8'h8C);

    // one long read spanning the end of busy
    cmd(8'h06, 8'h00, 8); mWel = 1'b1;
    cmd(8'h01, 8'h74, 16);
    xfer(8'h05, 8'h00, 8 + 8 * 20, f, l, h);
    chk("R9 first polled byte busy", f, 8'h8F);
    chk("R9 last polled byte committed", l, 8'h04);
    chk("R3 drive during long read", 8'(h), 8'h00);
    mProt = 3'b001; mWel = 1'b0;

    for (int it = 0; it < 60; it++) begin
      int kind;
      logic [7:0] op, d;
      kind = $urandom_range(0, 6);
      d = 8'($urandom);
      case (kind)
        0: begin cmd(8'h06, 8'h00, 8); mWel = 1'b1; checkStat("R4 random latch set"); end
        1: begin cmd(8'h04, 8'h00, 8); mWel = 1'b0; checkStat("R4 random latch clear"); end
        2: begin
          cmd(8'h01, d, 16);
          if (mWel) waitCommit(d);
          else checkStat("R7 random refused write");
        end
        3: begin
          op = 8'($urandom);
          if (op == 8'h01 || op == 8'h04 || op == 8'h05 || op == 8'h06) op = op ^ 8'h80;
          cmd(op, d, 8 + 8 * $urandom_range(0, 1));
          checkStat("R10 random unknown opcode");
        end
        4: begin
          op = $urandom_range(0, 1) ? 8'h06 : 8'h04;
          cmd(op, 8'h00, $urandom_range(1, 7));
          checkStat("R5 random truncated command");
        end
        5: begin
          if ($urandom_range(0, 1) == 1) cmd(8'h06, 8'h00, $urandom_range(9, 12));
          else cmd(8'h01, d, $urandom_range(17, 20));
          checkStat("R5 random overlong command");
        end
        default: begin
          xfer(8'h05, 8'h00, 8 + 8 * $urandom_range(1, 3), f, l, h);
          chk("R2 random read first byte", f, expStat(1'b0));
          chk("R9 random read repeated byte", l, expStat(1'b0));
        end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule